// File: doc/BRIEF.md
# TLP Header Trace Filter

This block sits beside the transaction layer of one PCIe core. It looks at each TLP header as it passes and decides whether a trace recorder downstream should capture it. Every packet comes with a 4-dword header, a direction flag, a peer-to-peer DMA flag and the index of the root port it crosses. The block accepts or drops the packet and presents the header, one cycle later, with a capture strobe.

Software sets up four things while tracing is stopped. The first is the target kind: a whole root port, or one function picked by its bus/device/function ID. The second is the port index or function ID. The third is the packet class to keep, and the fourth is the direction policy. Each write is checked against the ports that exist on the core and the bus ranges below them. A bad write is dropped as a whole. The current setting is always visible on the `cur_*` outputs.

A two-state machine follows the `trace_run` input. In the state `ST_IDLE`, configuration writes are taken and nothing is captured. The transition `T_START` (trace_run high) leads to `ST_RUN`, where packets are filtered and configuration writes are ignored. The transition `T_STOP` (trace_run low) returns to `ST_IDLE`. Each transition takes effect at the next clock edge.

Top module: `tlp_trace_filter`

## Requirements
- R1: After reset the setting is port kind (`cur_fn_mode`=0), port 0, class code 0 (posted), direction code 0 (rx), and `cap_valid` is 0.
- R2: The class comes from the header fields Fmt = bits [127:125] and Type = bits [124:120]. Posted means a memory write (Fmt 010/011, Type 00000) or a message (Fmt 001/011, Type 10xxx). Non-posted means a memory read (Fmt 000/001, Type 00000), a locked read (Type 00001), I/O (Type 00010) or configuration (Type 00100/00101). Completions are Type 01010/01011. Every other encoding is class "other".
- R3: Class code 0 keeps posted packets, code 1 keeps non-posted, code 2 keeps completions, and code 3 keeps every packet, including class "other".
- R4: Direction code 0 keeps packets with `pkt_dir_tx`=0, code 1 keeps packets with `pkt_dir_tx`=1, and code 2 keeps both.
- R5: Direction code 3 keeps both directions but drops every packet with `pkt_p2p`=1.
- R6: In port kind, a packet is kept only when `pkt_port` equals the target port index.
- R7: In function kind, a request or message is kept when its requester ID (bits [95:80]) equals the target ID. A completion is kept when either its completer ID (bits [95:80]) or its requester ID (bits [63:48]) equals the target ID.
- R8: A write whose target is not available is dropped and the previous setting is kept. In port kind, the port's bit in `port_avail` is clear. In function kind, the ID's bus (`cfg_rid[15:8]`) lies in no available port's `[lo,hi]` bus range.
- R9: A write with a class code or direction code above 3 is dropped whole, including its target fields.
- R10: Configuration writes made while the machine is in `ST_RUN` have no effect.
- R11: No packet is captured in `ST_IDLE`. The state follows `trace_run` one clock later.
- R12: `cap_valid` rises in the cycle after an accepted `pkt_valid`, and `cap_hdr` then holds that packet's header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_run | input | 1 | Tracing enable; drives the run/idle state |
| pkt_valid | input | 1 | Header strobe |
| pkt_hdr | input | 128 | TLP header, dword 0 in bits [127:96] |
| pkt_dir_tx | input | 1 | 0 = received by the root port, 1 = sent by it |
| pkt_p2p | input | 1 | Packet is a peer-to-peer DMA access |
| pkt_port | input | 2 | Root-port index the packet crosses |
| port_avail | input | 4 | One bit per root port present on the core |
| port_bus_lo | input | 32 | Lowest bus number below each port, 8 bits per port |
| port_bus_hi | input | 32 | Highest bus number below each port, 8 bits per port |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fn_mode | input | 1 | 0 = port target, 1 = function target |
| cfg_port | input | 2 | Target port index |
| cfg_rid | input | 16 | Target bus/device/function ID |
| cfg_type | input | 3 | Class code |
| cfg_dir | input | 3 | Direction code |
| cur_fn_mode | output | 1 | Current target kind |
| cur_port | output | 2 | Current target port |
| cur_rid | output | 16 | Current target ID |
| cur_type | output | 3 | Current class code |
| cur_dir | output | 3 | Current direction code |
| cap_valid | output | 1 | Capture strobe |
| cap_hdr | output | 128 | Header of the captured packet |

## Verification
The bench sends every class encoding under all four class codes. A classifier that mixes up a locked read, an I/O write or a message with data would then keep the wrong packets. It sends peer-to-peer packets in both directions under code 3, so a design that treats code 3 as plain both-directions would leak them. It also sends completions whose match sits only in the completer field or only in the requester field; a matcher that looks at one field would lose half of them. Bad targets, out-of-range codes and writes made while running are each followed by a readback and by packets. A design that took part of a bad write, or took a write mid-trace, would show a changed setting or changed filtering. Back-to-back packets check that each header leaves paired with its own strobe.

// File: rtl/tlp_trace_pkg.sv
package tlp_trace_pkg;

    typedef enum logic [1:0] {
        CLS_POSTED    = 2'd0,
        CLS_NONPOSTED = 2'd1,
        CLS_CPL       = 2'd2,
        CLS_OTHER     = 2'd3
    } tlp_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } trc_state_e;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] TSEL_POSTED    = 3'd0;
    localparam logic [CODE_W-1:0] TSEL_NONPOSTED = 3'd1;
    localparam logic [CODE_W-1:0] TSEL_CPL       = 3'd2;
    localparam logic [CODE_W-1:0] TSEL_ALL       = 3'd3;

    localparam logic [CODE_W-1:0] DSEL_RX        = 3'd0;
    localparam logic [CODE_W-1:0] DSEL_TX        = 3'd1;
    localparam logic [CODE_W-1:0] DSEL_BOTH      = 3'd2;
    localparam logic [CODE_W-1:0] DSEL_BOTH_NOP2P = 3'd3;

    localparam logic [CODE_W-1:0] CODE_MAX = 3'd3;

endpackage

// File: rtl/tlp_hdr_classify.sv
module tlp_hdr_classify
    import tlp_trace_pkg::*;
#(
    parameter int HDR_W = 128
) (
    input  logic [HDR_W-1:0] hdr,
    output tlp_class_e       cls,
    output logic             is_cpl,
    output logic [15:0]      id_dw1,
    output logic [15:0]      id_dw2
);
    localparam int DW0_HI = HDR_W - 1;
    localparam int DW1_HI = HDR_W - 33;
    localparam int DW2_HI = HDR_W - 65;

    logic [2:0] fmt;
    logic [4:0] typ;

    assign fmt    = hdr[DW0_HI -: 3];
    assign typ    = hdr[DW0_HI-3 -: 5];
    assign id_dw1 = hdr[DW1_HI -: 16];
    assign id_dw2 = hdr[DW2_HI -: 16];

    always_comb begin
        cls = CLS_OTHER;
        if (!fmt[2]) begin
            casez (typ)
                5'b00000: cls = fmt[1] ? CLS_POSTED : CLS_NONPOSTED;
                5'b00001: cls = fmt[1] ? CLS_OTHER  : CLS_NONPOSTED;
                5'b00010: cls = fmt[0] ? CLS_OTHER  : CLS_NONPOSTED;
                5'b0010?: cls = fmt[0] ? CLS_OTHER  : CLS_NONPOSTED;
                5'b10???: cls = fmt[0] ? CLS_POSTED : CLS_OTHER;
                5'b0101?: cls = fmt[0] ? CLS_OTHER  : CLS_CPL;
                default:  cls = CLS_OTHER;
            endcase
        end
    end

    assign is_cpl = (cls == CLS_CPL);

endmodule

// File: rtl/trace_cfg_ctrl.sv
module trace_cfg_ctrl
    import tlp_trace_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PORT_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trace_run,
    input  logic [NPORT-1:0]    port_avail,
    input  logic [NPORT*8-1:0]  port_bus_lo,
    input  logic [NPORT*8-1:0]  port_bus_hi,
    input  logic                cfg_wr,
    input  logic                cfg_fn_mode,
    input  logic [PORT_W-1:0]   cfg_port,
    input  logic [15:0]         cfg_rid,
    input  logic [CODE_W-1:0]   cfg_type,
    input  logic [CODE_W-1:0]   cfg_dir,
    output logic                running,
    output logic                cur_fn_mode,
    output logic [PORT_W-1:0]   cur_port,
    output logic [15:0]         cur_rid,
    output logic [CODE_W-1:0]   cur_type,
    output logic [CODE_W-1:0]   cur_dir
);
    trc_state_e state_q, state_d;

    logic [NPORT-1:0] bus_in_port;
    logic [7:0]       tgt_bus;
    logic             port_ok, fn_ok, tgt_ok, codes_ok, wr_take;

    assign tgt_bus = cfg_rid[15:8];

    // one bus-window compare per root port
    for (genvar p = 0; p < NPORT; p++) begin : g_win
        logic [7:0] lo, hi;
        assign lo = port_bus_lo[p*8 +: 8];
        assign hi = port_bus_hi[p*8 +: 8];
        assign bus_in_port[p] = port_avail[p] && (tgt_bus >= lo) && (tgt_bus <= hi);
    end

    assign port_ok  = (int'(cfg_port) < NPORT) && port_avail[cfg_port];
    assign fn_ok    = |bus_in_port;
    assign tgt_ok   = cfg_fn_mode ? fn_ok : port_ok;
    assign codes_ok = (cfg_type <= CODE_MAX) && (cfg_dir <= CODE_MAX);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: T_START and T_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trace_run)  state_d = ST_RUN;
            ST_RUN:  if (!trace_run) state_d = ST_IDLE;
        endcase
    end

    // outputs: settings may change only in ST_IDLE
    always_comb begin
        wr_take = 1'b0;
        unique case (state_q)
            ST_IDLE: wr_take = cfg_wr && tgt_ok && codes_ok;
            ST_RUN:  wr_take = 1'b0;
        endcase
    end

    assign running = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_fn_mode <= 1'b0;
            cur_port    <= '0;
            cur_rid     <= '0;
            cur_type    <= TSEL_POSTED;
            cur_dir     <= DSEL_RX;
        end else if (wr_take) begin
            cur_fn_mode <= cfg_fn_mode;
            cur_port    <= cfg_port;
            cur_rid     <= cfg_rid;
            cur_type    <= cfg_type;
            cur_dir     <= cfg_dir;
        end
    end

endmodule

// File: rtl/trace_match.sv
module trace_match
    import tlp_trace_pkg::*;
#(
    parameter int PORT_W = 2
) (
    input  tlp_class_e          cls,
    input  logic                is_cpl,
    input  logic [15:0]         id_dw1,
    input  logic [15:0]         id_dw2,
    input  logic                pkt_dir_tx,
    input  logic                pkt_p2p,
    input  logic [PORT_W-1:0]   pkt_port,
    input  logic                cur_fn_mode,
    input  logic [PORT_W-1:0]   cur_port,
    input  logic [15:0]         cur_rid,
    input  logic [CODE_W-1:0]   cur_type,
    input  logic [CODE_W-1:0]   cur_dir,
    output logic                hit
);
    logic type_hit, dir_hit, tgt_hit, id_hit;

    always_comb begin
        unique case (cur_type)
            TSEL_POSTED:    type_hit = (cls == CLS_POSTED);
            TSEL_NONPOSTED: type_hit = (cls == CLS_NONPOSTED);
            TSEL_CPL:       type_hit = (cls == CLS_CPL);
            TSEL_ALL:       type_hit = 1'b1;
            default:        type_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (cur_dir)
            DSEL_RX:         dir_hit = !pkt_dir_tx;
            DSEL_TX:         dir_hit = pkt_dir_tx;
            DSEL_BOTH:       dir_hit = 1'b1;
            DSEL_BOTH_NOP2P: dir_hit = !pkt_p2p;
            default:         dir_hit = 1'b0;
        endcase
    end

    // completions carry the completer in dword 1 and the requester in dword 2
    assign id_hit  = (id_dw1 == cur_rid) || (is_cpl && (id_dw2 == cur_rid));
    assign tgt_hit = cur_fn_mode ? id_hit : (pkt_port == cur_port);
    assign hit     = type_hit && dir_hit && tgt_hit;

endmodule

// File: rtl/tlp_trace_filter.sv
module tlp_trace_filter
    import tlp_trace_pkg::*;
#(
    parameter int HDR_DW = 4,
    parameter int NPORT  = 4,
    localparam int HDR_W  = 32 * HDR_DW,
    localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trace_run,
    input  logic                pkt_valid,
    input  logic [HDR_W-1:0]    pkt_hdr,
    input  logic                pkt_dir_tx,
    input  logic                pkt_p2p,
    input  logic [PORT_W-1:0]   pkt_port,
    input  logic [NPORT-1:0]    port_avail,
    input  logic [NPORT*8-1:0]  port_bus_lo,
    input  logic [NPORT*8-1:0]  port_bus_hi,
    input  logic                cfg_wr,
    input  logic                cfg_fn_mode,
    input  logic [PORT_W-1:0]   cfg_port,
    input  logic [15:0]         cfg_rid,
    input  logic [2:0]          cfg_type,
    input  logic [2:0]          cfg_dir,
    output logic                cur_fn_mode,
    output logic [PORT_W-1:0]   cur_port,
    output logic [15:0]         cur_rid,
    output logic [2:0]          cur_type,
    output logic [2:0]          cur_dir,
    output logic                cap_valid,
    output logic [HDR_W-1:0]    cap_hdr
);
    tlp_class_e  cls;
    logic        is_cpl;
    logic [15:0] id_dw1, id_dw2;
    logic        cfg_running;
    logic        hit;

    tlp_hdr_classify #(.HDR_W(HDR_W)) u_cls (
        .hdr    (pkt_hdr),
        .cls    (cls),
        .is_cpl (is_cpl),
        .id_dw1 (id_dw1),
        .id_dw2 (id_dw2)
    );

    trace_cfg_ctrl #(.NPORT(NPORT), .PORT_W(PORT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .trace_run   (trace_run),
        .port_avail  (port_avail),
        .port_bus_lo (port_bus_lo),
        .port_bus_hi (port_bus_hi),
        .cfg_wr      (cfg_wr),
        .cfg_fn_mode (cfg_fn_mode),
        .cfg_port    (cfg_port),
        .cfg_rid     (cfg_rid),
        .cfg_type    (cfg_type),
        .cfg_dir     (cfg_dir),
        .running     (cfg_running),
        .cur_fn_mode (cur_fn_mode),
        .cur_port    (cur_port),
        .cur_rid     (cur_rid),
        .cur_type    (cur_type),
        .cur_dir     (cur_dir)
    );

    trace_match #(.PORT_W(PORT_W)) u_match (
        .cls         (cls),
        .is_cpl      (is_cpl),
        .id_dw1      (id_dw1),
        .id_dw2      (id_dw2),
        .pkt_dir_tx  (pkt_dir_tx),
        .pkt_p2p     (pkt_p2p),
        .pkt_port    (pkt_port),
        .cur_fn_mode (cur_fn_mode),
        .cur_port    (cur_port),
        .cur_rid     (cur_rid),
        .cur_type    (cur_type),
        .cur_dir     (cur_dir),
        .hit         (hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_hdr   <= '0;
        end else begin
            cap_valid <= pkt_valid && hit && cfg_running;
            cap_hdr   <= pkt_hdr;
        end
    end

endmodule

// File: rtl/trace_filter_chk.sv
module trace_filter_chk #(
    parameter int HDR_W  = 128,
    parameter int PORT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_valid,
    input logic [HDR_W-1:0]  pkt_hdr,
    input logic              pkt_p2p,
    input logic [PORT_W-1:0] pkt_port,
    input logic              run,
    input logic              cur_fn_mode,
    input logic [PORT_W-1:0] cur_port,
    input logic [15:0]       cur_rid,
    input logic [2:0]        cur_type,
    input logic [2:0]        cur_dir,
    input logic              cap_valid,
    input logic [HDR_W-1:0]  cap_hdr
);
    // R12
    cap_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> $past(pkt_valid));

    // R12
    hdr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (cap_hdr == $past(pkt_hdr)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> $past(run));

    // R10
    run_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(cur_type) && $stable(cur_dir) && $stable(cur_port)
                 && $stable(cur_rid) && $stable(cur_fn_mode)));

    // R9
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_type <= 3'd3) && (cur_dir <= 3'd3));

    // R5
    nop2p_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && ($past(cur_dir) == 3'd3)) |-> !$past(pkt_p2p));

    // R6
    port_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !$past(cur_fn_mode)) |-> ($past(pkt_port) == $past(cur_port)));

endmodule

bind tlp_trace_filter trace_filter_chk #(.HDR_W(HDR_W), .PORT_W(PORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_valid   (pkt_valid),
    .pkt_hdr     (pkt_hdr),
    .pkt_p2p     (pkt_p2p),
    .pkt_port    (pkt_port),
    .run         (cfg_running),
    .cur_fn_mode (cur_fn_mode),
    .cur_port    (cur_port),
    .cur_rid     (cur_rid),
    .cur_type    (cur_type),
    .cur_dir     (cur_dir),
    .cap_valid   (cap_valid),
    .cap_hdr     (cap_hdr)
);

// File: tb/tb_tlp_trace_filter.sv
module tb_tlp_trace_filter;

    localparam time PERIOD = 8ns;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         trace_run;
    logic         pkt_valid;
    logic [127:0] pkt_hdr;
    logic         pkt_dir_tx;
    logic         pkt_p2p;
    logic [1:0]   pkt_port;
    logic [3:0]   port_avail;
    logic [31:0]  port_bus_lo;
    logic [31:0]  port_bus_hi;
    logic         cfg_wr;
    logic         cfg_fn_mode;
    logic [1:0]   cfg_port;
    logic [15:0]  cfg_rid;
    logic [2:0]   cfg_type;
    logic [2:0]   cfg_dir;
    logic         cur_fn_mode;
    logic [1:0]   cur_port;
    logic [15:0]  cur_rid;
    logic [2:0]   cur_type;
    logic [2:0]   cur_dir;
    logic         cap_valid;
    logic [127:0] cap_hdr;

    int n_chk  = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    tlp_trace_filter dut (
        .clk(clk), .rst_n(rst_n), .trace_run(trace_run),
        .pkt_valid(pkt_valid), .pkt_hdr(pkt_hdr), .pkt_dir_tx(pkt_dir_tx),
        .pkt_p2p(pkt_p2p), .pkt_port(pkt_port), .port_avail(port_avail),
        .port_bus_lo(port_bus_lo), .port_bus_hi(port_bus_hi),
        .cfg_wr(cfg_wr), .cfg_fn_mode(cfg_fn_mode), .cfg_port(cfg_port),
        .cfg_rid(cfg_rid), .cfg_type(cfg_type), .cfg_dir(cfg_dir),
        .cur_fn_mode(cur_fn_mode), .cur_port(cur_port), .cur_rid(cur_rid),
        .cur_type(cur_type), .cur_dir(cur_dir),
        .cap_valid(cap_valid), .cap_hdr(cap_hdr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input logic [2:0] fmt, input logic [4:0] typ,
                                        input logic [15:0] id1, input logic [15:0] id2,
                                        input logic [31:0] tag);
        return {fmt, typ, 24'h000001, id1, 16'h00ff, id2, 16'h0000, tag};
    endfunction

    // class per R2: 0 posted, 1 non-posted, 2 completion, 3 other
    function automatic int exp_cls(input logic [2:0] fmt, input logic [4:0] typ);
        if (typ == 5'b00000 && (fmt == 3'b010 || fmt == 3'b011)) return 0;
        if (typ[4:3] == 2'b10 && (fmt == 3'b001 || fmt == 3'b011)) return 0;
        if ((typ == 5'b00000 || typ == 5'b00001) && (fmt == 3'b000 || fmt == 3'b001)) return 1;
        if ((typ == 5'b00010 || typ == 5'b00100 || typ == 5'b00101) &&
            (fmt == 3'b000 || fmt == 3'b010)) return 1;
        if ((typ == 5'b01010 || typ == 5'b01011) && (fmt == 3'b000 || fmt == 3'b010)) return 2;
        return 3;
    endfunction

    task automatic send(input logic [127:0] h, input logic dtx, input logic p2p,
                        input logic [1:0] port, input bit exp, input string req);
        pkt_valid  = 1'b1;
        pkt_hdr    = h;
        pkt_dir_tx = dtx;
        pkt_p2p    = p2p;
        pkt_port   = port;
        @(negedge clk);
        pkt_valid  = 1'b0;
        chk(cap_valid == exp, req, "cap_valid", 128'(cap_valid), 128'(exp));
        if (exp) chk(cap_hdr == h, req, "cap_hdr", cap_hdr, h);
    endtask

    task automatic cfg_write(input logic fn, input logic [1:0] port, input logic [15:0] rid,
                             input logic [2:0] typ, input logic [2:0] dir);
        cfg_wr = 1'b1; cfg_fn_mode = fn; cfg_port = port; cfg_rid = rid;
        cfg_type = typ; cfg_dir = dir;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_run(input logic r);
        trace_run = r;
        @(negedge clk);
    endtask

    task automatic chk_cfg(input logic fn, input logic [1:0] port, input logic [15:0] rid,
                           input logic [2:0] typ, input logic [2:0] dir, input string req);
        chk(cur_fn_mode == fn, req, "cur_fn_mode", 128'(cur_fn_mode), 128'(fn));
        chk(cur_port == port, req, "cur_port", 128'(cur_port), 128'(port));
        chk(cur_rid == rid, req, "cur_rid", 128'(cur_rid), 128'(rid));
        chk(cur_type == typ, req, "cur_type", 128'(cur_type), 128'(typ));
        chk(cur_dir == dir, req, "cur_dir", 128'(cur_dir), 128'(dir));
    endtask

    // R1: reset values and default filtering
    task automatic t_reset;
        chk_cfg(1'b0, 2'd0, 16'h0, 3'd0, 3'd0, "R1");
        chk(cap_valid == 1'b0, "R1", "cap_valid after reset", 128'(cap_valid), 128'd0);
        set_run(1'b1);
        send(mk(3'b010, 5'b00000, 16'h0100, 16'h0, 32'h11), 1'b0, 1'b0, 2'd0, 1'b1, "R1");
        send(mk(3'b000, 5'b00000, 16'h0100, 16'h0, 32'h12), 1'b0, 1'b0, 2'd0, 1'b0, "R1");
        send(mk(3'b010, 5'b00000, 16'h0100, 16'h0, 32'h13), 1'b1, 1'b0, 2'd0, 1'b0, "R1");
        send(mk(3'b010, 5'b00000, 16'h0100, 16'h0, 32'h14), 1'b0, 1'b0, 2'd1, 1'b0, "R1");
        set_run(1'b0);
    endtask

    // R11: nothing captured while idle; run takes effect one clock later
    task automatic t_idle;
        send(mk(3'b010, 5'b00000, 16'h0, 16'h0, 32'h21), 1'b0, 1'b0, 2'd0, 1'b0, "R11");
        trace_run = 1'b1;
        send(mk(3'b010, 5'b00000, 16'h0, 16'h0, 32'h22), 1'b0, 1'b0, 2'd0, 1'b0, "R11");
        send(mk(3'b010, 5'b00000, 16'h0, 16'h0, 32'h23), 1'b0, 1'b0, 2'd0, 1'b1, "R11");
        set_run(1'b0);
    endtask

    // R2 and R3: every class encoding under each class code
    task automatic t_classify;
        logic [2:0] fmts [11] = '{3'b010, 3'b000, 3'b000, 3'b010, 3'b000, 3'b010,
                                  3'b001, 3'b011, 3'b000, 3'b010, 3'b011};
        logic [4:0] typs [11] = '{5'b00000, 5'b00000, 5'b00001, 5'b00010, 5'b00100,
                                  5'b00101, 5'b10000, 5'b10100, 5'b01010, 5'b01010, 5'b01100};
        for (int s = 0; s < 4; s++) begin
            cfg_write(1'b0, 2'd0, 16'h0, 3'(s), 3'd2);
            set_run(1'b1);
            for (int i = 0; i < 11; i++) begin
                send(mk(fmts[i], typs[i], 16'h0, 16'h0, 32'(i + 16 * s)), 1'(i % 2), 1'b0, 2'd0,
                     (s == 3) || (exp_cls(fmts[i], typs[i]) == s), "R2 R3");
            end
            set_run(1'b0);
        end
    endtask

    // R4 and R5: direction policy including peer-to-peer exclusion
    task automatic t_direction;
        for (int d = 0; d < 4; d++) begin
            cfg_write(1'b0, 2'd1, 16'h0, 3'd3, 3'(d));
            set_run(1'b1);
            for (int k = 0; k < 4; k++) begin
                bit dtx, p2p, e;
                dtx = k[0]; p2p = k[1];
                case (d)
                    0: e = !dtx;
                    1: e = dtx;
                    2: e = 1'b1;
                    default: e = !p2p;
                endcase
                send(mk(3'b000, 5'b01010, 16'h0, 16'h0, 32'(100 + 4 * d + k)), dtx, p2p, 2'd1, e,
                     (d == 3) ? "R5" : "R4");
            end
            set_run(1'b0);
        end
    endtask

    // R6: port target keeps only its own port
    task automatic t_port;
        cfg_write(1'b0, 2'd2, 16'h0, 3'd3, 3'd2);
        set_run(1'b1);
        for (int p = 0; p < 4; p++)
            send(mk(3'b010, 5'b00000, 16'h0, 16'h0, 32'(200 + p)), 1'b0, 1'b0, 2'(p), p == 2, "R6");
        set_run(1'b0);
    endtask

    // R7: function target matches requester or completer fields
    task automatic t_rid;
        cfg_write(1'b1, 2'd0, 16'h0210, 3'd3, 3'd2);
        chk_cfg(1'b1, 2'd0, 16'h0210, 3'd3, 3'd2, "R7");
        set_run(1'b1);
        send(mk(3'b000, 5'b00000, 16'h0210, 16'h0, 32'h301), 1'b0, 1'b0, 2'd3, 1'b1, "R7 request");
        send(mk(3'b000, 5'b00000, 16'h0211, 16'h0210, 32'h302), 1'b0, 1'b0, 2'd0, 1'b0, "R7 request dw2");
        send(mk(3'b010, 5'b01010, 16'h0800, 16'h0210, 32'h303), 1'b1, 1'b0, 2'd0, 1'b1, "R7 cpl requester");
        send(mk(3'b000, 5'b01010, 16'h0210, 16'h0900, 32'h304), 1'b0, 1'b0, 2'd1, 1'b1, "R7 cpl completer");
        send(mk(3'b010, 5'b01010, 16'h0800, 16'h0900, 32'h305), 1'b0, 1'b0, 2'd0, 1'b0, "R7 cpl none");
        set_run(1'b0);
    endtask

    // R8: unavailable targets are refused
    task automatic t_bad_target;
        cfg_write(1'b0, 2'd1, 16'h0, 3'd0, 3'd0);
        cfg_write(1'b0, 2'd3, 16'h0, 3'd1, 3'd1);
        chk_cfg(1'b0, 2'd1, 16'h0, 3'd0, 3'd0, "R8 port");
        cfg_write(1'b1, 2'd1, 16'h0900, 3'd1, 3'd1);
        chk_cfg(1'b0, 2'd1, 16'h0, 3'd0, 3'd0, "R8 function");
        set_run(1'b1);
        send(mk(3'b010, 5'b00000, 16'h0900, 16'h0, 32'h401), 1'b0, 1'b0, 2'd1, 1'b1, "R8");
        send(mk(3'b010, 5'b00000, 16'h0900, 16'h0, 32'h402), 1'b0, 1'b0, 2'd3, 1'b0, "R8");
        set_run(1'b0);
    endtask

    // R9: out-of-range codes drop the whole write
    task automatic t_bad_codes;
        cfg_write(1'b0, 2'd2, 16'h0, 3'd5, 3'd0);
        chk_cfg(1'b0, 2'd1, 16'h0, 3'd0, 3'd0, "R9 type");
        cfg_write(1'b1, 2'd0, 16'h0210, 3'd2, 3'd7);
        chk_cfg(1'b0, 2'd1, 16'h0, 3'd0, 3'd0, "R9 dir");
        set_run(1'b1);
        send(mk(3'b000, 5'b01010, 16'h0210, 16'h0, 32'h501), 1'b0, 1'b0, 2'd2, 1'b0, "R9");
        set_run(1'b0);
    endtask

    // R10: writes while running are ignored
    task automatic t_run_lock;
        set_run(1'b1);
        cfg_write(1'b0, 2'd2, 16'h0, 3'd3, 3'd2);
        chk_cfg(1'b0, 2'd1, 16'h0, 3'd0, 3'd0, "R10");
        send(mk(3'b000, 5'b00000, 16'h0, 16'h0, 32'h601), 1'b1, 1'b0, 2'd2, 1'b0, "R10");
        send(mk(3'b010, 5'b00000, 16'h0, 16'h0, 32'h602), 1'b0, 1'b0, 2'd1, 1'b1, "R10");
        set_run(1'b0);
    endtask

    // R12: back-to-back headers stay paired with their strobes
    task automatic t_latency;
        cfg_write(1'b0, 2'd0, 16'h0, 3'd3, 3'd2);
        set_run(1'b1);
        for (int i = 0; i < 8; i++)
            send(mk(3'b010, 5'b00000, 16'(i), 16'h0, 32'hA000 + 32'(i)), 1'b0, 1'b0,
                 (i % 3 == 0) ? 2'd1 : 2'd0, (i % 3 != 0), "R12");
        set_run(1'b0);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trace_run = 1'b0; pkt_valid = 1'b0; pkt_hdr = '0;
        pkt_dir_tx = 1'b0; pkt_p2p = 1'b0; pkt_port = '0;
        port_avail  = 4'b0111;
        port_bus_lo = {8'd9, 8'd8, 8'd4, 8'd1};
        port_bus_hi = {8'd15, 8'd8, 8'd7, 8'd3};
        cfg_wr = 1'b0; cfg_fn_mode = 1'b0; cfg_port = '0; cfg_rid = '0;
        cfg_type = '0; cfg_dir = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_classify();
        t_direction();
        t_port();
        t_rid();
        t_bad_target();
        t_bad_codes();
        t_run_lock();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule